// File: doc/BRIEF.md
# Round-Robin Bus Arbiter with Preemption Timer

This block is the central arbiter for a shared parallel bus with up to eight masters. Each master has an active-low request and an active-low grant. The arbiter watches the bus-busy strobes (`frame_n`, `irdy_n`) and picks the next owner in round-robin order. How a grant passes from one master to the next depends on whether the bus is in use.

A preemption timer counts how long another master has waited while the current owner keeps its request asserted. When the programmed limit is reached, the owner loses its grant. Preemption can be switched off. When no master requests, the last owner keeps its grant so that it parks the bus.

A strap-style input (`ext_arb`) hands arbitration to an outside device. While it is high, every grant output stays inactive.

Top module: `busarb_core`

## Requirements
- R1: At most one bit of `gnt_n` is low at any time. While `rst_n` is low, all grants are high.
- R2: A new owner is chosen round-robin. The search starts at the index after the current or most recent owner, wraps around, and reaches that owner last.
- R3: If a handoff is wanted while the bus is idle (`frame_n` and `irdy_n` both high), the current grant goes high at the next edge. The next grant is asserted one edge later, which leaves a cycle with no grant.
- R4: If a handoff is wanted while the bus is busy (`frame_n` or `irdy_n` low), the old grant is removed and the new one is asserted at the same clock edge.
- R5: Suppose the owner keeps its request low and another master requests. The handoff then happens at the edge ending the L-th consecutive cycle of waiting, where L is the time-to-preempt. An owner whose request is high hands over at the next edge when another master requests.
- R6: `preempt_sel` codes 0, 1, 2, 3 and 4 select L = 8, 16, 32, 64 and 128 clocks. Codes 5 to 7 select 32.
- R7: `preempt_off` is active-high disable. When it is 0, preemption is on. When it is 1, an owner that keeps its request is never preempted.
- R8: The wait count restarts from zero whenever the owner changes, or in any cycle in which no other master is requesting.
- R9: When no master requests, the grant stays with the current owner. After reset with no requests, master 0 receives the parking grant.
- R10: While `ext_arb` is 1, all grants are high from the next edge onward. After `ext_arb` falls, a grant is issued at the next edge by the round-robin rule, or to the last owner if nobody requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | NUM_MST | Active-low request, one bit per master |
| frame_n | input | 1 | Active-low frame strobe of the bus |
| irdy_n | input | 1 | Active-low initiator-ready strobe of the bus |
| preempt_off | input | 1 | 1 disables preemption, 0 enables it |
| preempt_sel | input | 3 | Time-to-preempt select code |
| ext_arb | input | 1 | 1 hands arbitration to an outside device; grants inactive |
| gnt_n | output | NUM_MST | Active-low grant, one bit per master |

## Verification
Steady requests from all eight masters on an idle bus make preemption walk the grant through every index. This shows the round-robin order and the one-cycle gap. The same load under a held-low `frame_n` or `irdy_n` tells the same-edge busy handoff apart from the idle one.

Two masters that both keep their requests are run under each of the eight select codes, and again with preemption off. This pins down every limit, the fallback codes, and the disable. A waiting master whose request toggles separates counter restart from accumulation. Long random mixes of requests, bus strobes and the external-arbiter input then test all these rules together.

// File: rtl/busarb_pkg.sv
`timescale 1ns/1ps
package busarb_pkg;

  // Preemption limit in clocks for a select code; codes above 4 fall back to 32.
  function automatic int unsigned preempt_limit(input logic [2:0] sel);
    if (sel <= 3'd4) return 32'd8 << sel;
    else             return 32'd32;
  endfunction

endpackage

// File: rtl/busarb_rr_pick.sv
`timescale 1ns/1ps
module busarb_rr_pick #(
  parameter int NUM_MST   = 8,
  parameter int IW        = 3,
  parameter bit WITH_BASE = 1'b1
) (
  input  logic [NUM_MST-1:0] req,
  input  logic [IW-1:0]      base,
  output logic               found,
  output logic [IW-1:0]      idx
);

  logic          lp_found;
  logic [IW-1:0] lp_idx;

  // Scan from base+N-1 down to base+1 so that the nearest index after base wins.
  always_comb begin
    lp_found = 1'b0;
    lp_idx   = base;
    for (int k = NUM_MST - 1; k >= 1; k--) begin
      int p;
      p = (int'(base) + k) % NUM_MST;
      if (req[IW'(p)]) begin
        lp_found = 1'b1;
        lp_idx   = IW'(p);
      end
    end
  end

  generate
    if (WITH_BASE) begin : g_incl
      assign found = lp_found | req[base];
      assign idx   = lp_found ? lp_idx : base;
    end else begin : g_excl
      assign found = lp_found;
      assign idx   = lp_idx;
    end
  endgenerate

  // R2
  always_comb begin
    if (found) pick_valid_chk: assert (req[idx]);
  end

endmodule

// File: rtl/busarb_preempt_tmr.sv
`timescale 1ns/1ps
module busarb_preempt_tmr
  import busarb_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       count_en,
  input  logic       clr,
  input  logic       preempt_off,
  input  logic [2:0] preempt_sel,
  output logic       expire
);

  logic [CNT_W-1:0] cnt_q;
  int unsigned      limit;

  assign limit  = preempt_limit(preempt_sel);
  assign expire = count_en && !preempt_off &&
                  ((32'(cnt_q) + 32'd1) >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr)              cnt_q <= '0;
    else if (cnt_q != '1)      cnt_q <= cnt_q + 1'b1;
  end

  // R7
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preempt_off |-> !expire);

  // R6
  limit_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(limit) && (limit >= 32'd8) && (limit <= 32'd128));

endmodule

// File: rtl/busarb_core.sv
`timescale 1ns/1ps
module busarb_core #(
  parameter int NUM_MST = 8,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_MST-1:0] req_n,
  input  logic               frame_n,
  input  logic               irdy_n,
  input  logic               preempt_off,
  input  logic [2:0]         preempt_sel,
  input  logic               ext_arb,
  output logic [NUM_MST-1:0] gnt_n
);

  localparam int IW = (NUM_MST > 1) ? $clog2(NUM_MST) : 1;

  logic [NUM_MST-1:0] req_v;
  logic               bus_busy;
  logic [IW-1:0]      last_q;
  logic               gnt_v_q;
  logic [NUM_MST-1:0] gnt_q;

  logic               any_found, oth_found;
  logic [IW-1:0]      any_idx, oth_idx;
  logic               hold_req, tmr_en, tmr_clr, tmr_expire, move;

  assign req_v    = ~req_n;
  assign bus_busy = !frame_n || !irdy_n;

  busarb_rr_pick #(.NUM_MST(NUM_MST), .IW(IW), .WITH_BASE(1'b1)) pick_any_i (
    .req(req_v), .base(last_q), .found(any_found), .idx(any_idx));

  busarb_rr_pick #(.NUM_MST(NUM_MST), .IW(IW), .WITH_BASE(1'b0)) pick_oth_i (
    .req(req_v), .base(last_q), .found(oth_found), .idx(oth_idx));

  assign hold_req = req_v[last_q];
  assign tmr_en   = gnt_v_q && !ext_arb && oth_found && hold_req;
  assign move     = gnt_v_q && !ext_arb && oth_found && (!hold_req || tmr_expire);
  assign tmr_clr  = !tmr_en || move;

  busarb_preempt_tmr #(.CNT_W(CNT_W)) tmr_i (
    .clk(clk), .rst_n(rst_n), .count_en(tmr_en), .clr(tmr_clr),
    .preempt_off(preempt_off), .preempt_sel(preempt_sel), .expire(tmr_expire));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_v_q <= 1'b0;
      last_q  <= '0;
    end else if (ext_arb) begin
      gnt_v_q <= 1'b0;
    end else if (!gnt_v_q) begin
      gnt_v_q <= 1'b1;
      if (any_found) last_q <= any_idx;
    end else if (move) begin
      if (bus_busy) last_q  <= oth_idx;
      else          gnt_v_q <= 1'b0;
    end
  end

  assign gnt_q = gnt_v_q ? (NUM_MST'(1) << last_q) : '0;
  assign gnt_n = ~gnt_q;

  // R1
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~gnt_n));

  // R3
  idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_v_q && !bus_busy) |=> ((gnt_q == $past(gnt_q)) || (gnt_q == '0)));

  // R4
  busy_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (move && bus_busy) |=> (gnt_v_q && (gnt_q != $past(gnt_q))));

  // R5
  preempt_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_expire |=> (gnt_q != $past(gnt_q)));

  // R9
  park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_v_q && (&req_n) && !ext_arb) |=> $stable(gnt_q));

  // R10
  ext_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_arb |=> (&gnt_n));

endmodule

// File: tb/busarb_core_tb.sv
`timescale 1ns/1ps
module busarb_core_tb_top;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req_n = '1;
  logic         frame_n = 1'b1;
  logic         irdy_n = 1'b1;
  logic         preempt_off = 1'b0;
  logic [2:0]   preempt_sel = 3'd2;
  logic         ext_arb = 1'b0;
  logic [N-1:0] gnt_n;

  int    vectors = 0;
  int    errors  = 0;
  string phase   = "R1";
  bit    done    = 1'b0;

  always #2 clk = ~clk;

  busarb_core #(.NUM_MST(N), .CNT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .preempt_off(preempt_off), .preempt_sel(preempt_sel), .ext_arb(ext_arb),
    .gnt_n(gnt_n));

  // Reference model: owner number, grant-present flag, wait counter.
  int lim_tab [8] = '{8, 16, 32, 64, 128, 32, 32, 32};
  int m_last = 0;
  int m_gv   = 0;
  int m_cnt  = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_last = 0; m_gv = 0; m_cnt = 0;
    end else begin
      int any_i, oth_i, lim;
      bit any_f, oth_f, hold, busy, expd;
      any_f = 0; oth_f = 0; any_i = m_last; oth_i = m_last;
      for (int k = 1; k <= N; k++) begin
        int c;
        c = (m_last + k) % N;
        if (!any_f && !req_n[c]) begin any_f = 1; any_i = c; end
        if (k < N && !oth_f && !req_n[c]) begin oth_f = 1; oth_i = c; end
      end
      lim  = lim_tab[preempt_sel];
      busy = (frame_n == 1'b0) || (irdy_n == 1'b0);
      hold = (req_n[m_last] == 1'b0);
      if (ext_arb) begin
        m_gv = 0; m_cnt = 0;
      end else if (m_gv == 0) begin
        m_gv = 1; m_cnt = 0;
        if (any_f) m_last = any_i;
      end else begin
        expd = oth_f && hold && !preempt_off && (m_cnt + 1 >= lim);
        if (oth_f && (!hold || expd)) begin
          m_cnt = 0;
          if (busy) m_last = oth_i;
          else      m_gv = 0;
        end else if (oth_f && hold) begin
          m_cnt = (m_cnt < 255) ? m_cnt + 1 : 255;
        end else begin
          m_cnt = 0;
        end
      end
    end
  end

  // Compare one nanosecond after every rising edge.
  always @(posedge clk) begin
    logic [N-1:0] exp_g;
    #1;
    exp_g = (m_gv != 0) ? ~(N'(1) << m_last) : '1;
    if (!done) begin
      vectors++;
      if (gnt_n !== exp_g) begin
        errors++;
        $display("FAIL %s: gnt_n actual %b expected %b at %0t", phase, gnt_n, exp_g, $time);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1: grants inactive under reset
    phase = "R1";
    cyc(4);
    rst_n = 1'b1;
    // R9: park on master 0, then on master 3 after it finishes
    phase = "R9";
    cyc(5);
    req_n = ~8'b0000_1000;
    cyc(6);
    req_n = '1;
    cyc(10);
    // R2: all masters request, idle bus, short limit rotates through every index
    phase = "R2";
    preempt_sel = 3'd0;
    req_n = '0;
    cyc(120);
    // R3: requests hand over on an idle bus as owners drop out
    phase = "R3";
    req_n = ~8'b0100_0010;
    cyc(4);
    req_n = ~8'b0100_0000;
    cyc(6);
    req_n = ~8'b0000_0010;
    cyc(6);
    // R4: busy bus, handoff at one edge
    phase = "R4";
    req_n = '0;
    frame_n = 1'b0;
    cyc(100);
    frame_n = 1'b1; irdy_n = 1'b0;
    req_n = ~8'b1001_0001;
    cyc(60);
    irdy_n = 1'b1;
    // R6: every select code with two persistent requesters
    phase = "R6";
    for (int s = 0; s < 8; s++) begin
      preempt_sel = 3'(s);
      req_n = ~8'b0001_0100;
      cyc(300);
    end
    // R7: preemption disabled holds the owner
    phase = "R7";
    preempt_off = 1'b1;
    preempt_sel = 3'd0;
    cyc(300);
    preempt_off = 1'b0;
    // R8: a waiting master that toggles restarts the wait count
    phase = "R8";
    preempt_sel = 3'd2;
    req_n = ~8'b0010_0000;
    cyc(4);
    for (int t = 0; t < 10; t++) begin
      req_n[7] = ~req_n[7];
      cyc(20);
    end
    // R10: external arbitration silences all grants
    phase = "R10";
    req_n = ~8'b0011_0000;
    ext_arb = 1'b1;
    cyc(20);
    ext_arb = 1'b0;
    cyc(10);
    ext_arb = 1'b1;
    req_n = '1;
    cyc(5);
    ext_arb = 1'b0;
    cyc(5);
    // R5: random mixes of all inputs
    phase = "R5";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 20) req_n = N'($urandom) | N'($urandom);
      else if (r < 25) req_n = N'($urandom);
      frame_n = ($urandom_range(0, 3) != 0);
      irdy_n  = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 199) == 0) preempt_sel = 3'($urandom);
      if ($urandom_range(0, 299) == 0) preempt_off = ~preempt_off;
      ext_arb = ($urandom_range(0, 149) == 0);
      cyc(1);
    end
    cyc(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule